// File: doc/BRIEF.md
# Serial flash command sequencer

This block runs one serial flash transaction at a time, as described by a single 32-bit command word. Each frame has a fixed order. An opcode byte goes out first. An optional address phase follows, taken from a separately written address register. Optional intermediate filler bytes come next, and a data phase of programmable length ends the frame. Chip select stays low for the whole frame. The serial clock is high for one system clock cycle in every bit slot.

Data moves one byte at a time through two holding registers. Output bytes are offered on a valid/ready pair. Input bytes are presented with a valid flag and released by an acknowledge. When the next output byte is missing, or the previous input byte has not been taken, the serial clock holds low. No byte is lost or invented. The data phase can run on one line, or on two or four lines when the command asks for a wide data phase. The two-or-four choice comes from a static input.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is idle: `busy`=0, `cs_n`=1, `sck`=0, `io_oe`=0, `rx_valid`=0 and `tx_ready`=0.
- R2: A command write while idle lowers `cs_n` and raises `busy` on the next cycle. The opcode in bits 31:24 is then sent first, as 8 serial slots, MSB first, on lane 0 with `io_oe`=4'b0001.
- R3: The frame-form field in bits 23:21 sets the address byte count. Values 0 and 1 send no address. Values 2 to 5 send 1 to 4 bytes. Values 6 and 7 send 4 bytes. Address bytes are the low bytes of the address register, most significant byte first, serial on lane 0.
- R4: The count in bits 18:16 adds that many 0x00 bytes after the address, sent serially on lane 0. Input lines are ignored during these bytes.
- R5: Bits 13:0 give the number of data bytes, and bit 15 set means the data goes out to the flash. A length of zero ends the frame right after the header.
- R6: A field-form value of 0 in bits 20:19 keeps data serial: output on lane 0, input sampled from lane 1, with lane 0 driven low during input. Any other value puts only the data phase on 2 lanes (`quad_lanes`=0, lanes 1:0) or on 4 lanes (`quad_lanes`=1, lanes 3:0). The higher-numbered lane carries the more significant bit. All enables are off during a wide input phase.
- R7: `tx_ready` is high only while output bytes of the current command remain unaccepted and the holding register is empty. When the next output byte is missing, `sck` stays low and no slot is sent.
- R8: A received byte appears on `rx_data` with `rx_valid`, and both hold until `rx_ack`. While a byte is unconsumed, the next input byte does not start and `sck` stays low.
- R9: `busy` stays high from the command write until the last bit slot of the frame has completed. Whenever `busy` is low, `cs_n`=1 and `sck`=0. Each `sck` high lasts exactly one cycle.
- R10: Command and address writes made while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| quad_lanes | input | 1 | Wide data phase uses 4 lanes (1) or 2 lanes (0) |
| addr_we | input | 1 | Address register write strobe |
| addr_wdata | input | 32 | Address value |
| cmd_we | input | 1 | Command word write strobe; starts a frame |
| cmd_wdata | input | 32 | Command word |
| tx_valid | input | 1 | Output data byte offered |
| tx_data | input | 8 | Output data byte |
| tx_ready | output | 1 | Output byte accepted when high with tx_valid |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Received byte |
| rx_ack | input | 1 | Consumes the received byte |
| busy | output | 1 | Frame in progress |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Flash select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
A bench flash model logs every lane value and enable at each rising `sck` and feeds response bits at each falling edge. Each frame is compared slot by slot against an expected stream built from the command fields. Random frames mix address counts, filler counts, lengths, directions and lane widths with short handshake gaps. This separates wrong field decoding, byte order and lane mapping.

Directed frames cover the following cases:
- Zero-length erase.
- Clipped frame-form values 0 and 7.
- Long holds on the first output byte and on the first unacknowledged input byte, which expose missing stalls.
- Writes poked in mid-frame, which would corrupt the frame in progress or the address kept for the next one.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        quad_lanes,
  input  logic        addr_we,
  input  logic [31:0] addr_wdata,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic        tx_valid,
  input  logic [7:0]  tx_data,
  output logic        tx_ready,
  output logic        rx_valid,
  output logic [7:0]  rx_data,
  input  logic        rx_ack,
  output logic        busy,
  output logic        sck,
  output logic        cs_n,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in
);
  localparam int LEN_W = 14;

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADR, S_INT, S_DAT, S_FIN} st_t;

  st_t              st, nst;
  logic [LEN_W-1:0] rem, nrem, len, tx_left;
  logic [2:0]       slot, last_slot, na, ni, c_na;
  logic             half, dout, wide, quad_r, tx_full;
  logic [7:0]       sh, nsh, src, shifted, tx_hold, abyte;
  logic [31:0]      adr;
  logic [1:0]       asel;
  logic [3:0]       drv_out, drv_oe;
  logic             in_dat, wide_now, load_tx, stall;

  assign busy     = (st != S_IDLE);
  assign tx_ready = (tx_left != '0) && !tx_full;

  assign in_dat    = (st == S_DAT);
  assign wide_now  = in_dat && wide;
  assign last_slot = wide_now ? (quad_r ? 3'd1 : 3'd3) : 3'd7;
  assign load_tx   = in_dat && dout && (slot == 3'd0);
  assign stall     = in_dat && (slot == 3'd0) && (dout ? !tx_full : rx_valid);
  assign src       = load_tx ? tx_hold : sh;

  wire [2:0] c_ff = cmd_wdata[23:21];
  assign c_na = (c_ff <= 3'd1) ? 3'd0 : (c_ff >= 3'd5) ? 3'd4 : c_ff - 3'd1;

  assign asel  = (st == S_OPC) ? 2'(na - 3'd1) : 2'(rem - 14'd2);
  assign abyte = adr[{asel, 3'b000} +: 8];

  always_comb begin
    if (wide_now && quad_r)  shifted = {sh[3:0], io_in};
    else if (wide_now)       shifted = {sh[5:0], io_in[1:0]};
    else                     shifted = {sh[6:0], io_in[1]};
  end

  always_comb begin
    if (in_dat && !dout) begin
      drv_out = 4'b0000;
      drv_oe  = wide ? 4'b0000 : 4'b0001;
    end else if (wide_now && quad_r) begin
      drv_out = src[7:4];
      drv_oe  = 4'b1111;
    end else if (wide_now) begin
      drv_out = {2'b00, src[7:6]};
      drv_oe  = 4'b0011;
    end else begin
      drv_out = {3'b000, src[7]};
      drv_oe  = 4'b0001;
    end
  end

  always_comb begin
    nst  = st;
    nrem = rem - 1'b1;
    nsh  = 8'h00;
    if (st == S_ADR && rem > 14'd1) begin
      nsh = abyte;
    end else if ((st == S_INT || st == S_DAT) && rem > 14'd1) begin
      nsh = 8'h00;
    end else if (st == S_OPC && na != 3'd0) begin
      nst  = S_ADR;
      nrem = 14'(na);
      nsh  = abyte;
    end else if ((st == S_OPC || st == S_ADR) && ni != 3'd0) begin
      nst  = S_INT;
      nrem = 14'(ni);
    end else if (st != S_DAT && len != '0) begin
      nst  = S_DAT;
      nrem = len;
    end else begin
      nst = S_FIN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rem <= '0; len <= '0; tx_left <= '0;
      slot <= '0; na <= '0; ni <= '0; half <= 1'b0;
      dout <= 1'b0; wide <= 1'b0; quad_r <= 1'b0;
      sh <= '0; adr <= '0; tx_hold <= '0; tx_full <= 1'b0;
      rx_data <= '0; rx_valid <= 1'b0;
      sck <= 1'b0; cs_n <= 1'b1; io_out <= '0; io_oe <= '0;
    end else begin
      if (tx_valid && tx_ready) begin
        tx_hold <= tx_data;
        tx_full <= 1'b1;
        tx_left <= tx_left - 1'b1;
      end
      if (rx_ack && rx_valid) rx_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (addr_we) adr <= addr_wdata;
          if (cmd_we) begin
            st      <= S_OPC;
            rem     <= 14'd1;
            sh      <= cmd_wdata[31:24];
            len     <= cmd_wdata[13:0];
            dout    <= cmd_wdata[15];
            ni      <= cmd_wdata[18:16];
            wide    <= (cmd_wdata[20:19] != 2'b00);
            na      <= c_na;
            quad_r  <= quad_lanes;
            tx_left <= cmd_wdata[15] ? cmd_wdata[13:0] : '0;
            slot    <= '0;
            half    <= 1'b0;
            cs_n    <= 1'b0;
          end
        end
        S_FIN: begin
          st     <= S_IDLE;
          cs_n   <= 1'b1;
          sck    <= 1'b0;
          io_out <= '0;
          io_oe  <= '0;
        end
        default: begin
          if (!half) begin
            sck <= 1'b0;
            if (!stall) begin
              io_out <= drv_out;
              io_oe  <= drv_oe;
              sh     <= src;
              half   <= 1'b1;
              if (load_tx) tx_full <= 1'b0;
            end
          end else begin
            sck  <= 1'b1;
            half <= 1'b0;
            if (slot == last_slot) begin
              slot <= '0;
              st   <= nst;
              rem  <= nrem;
              sh   <= nsh;
              if (in_dat && !dout) begin
                rx_data  <= shifted;
                rx_valid <= 1'b1;
              end
            end else begin
              slot <= slot + 1'b1;
              sh   <= shifted;
            end
          end
        end
      endcase
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !busy) |=> (busy && !cs_n)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sck)); // R9
  AST_SCK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sck |=> !sck); // R9
  AST_TX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dat && dout && !tx_full && slot == 3'd0 && !half) |=> !sck); // R7
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ack) |=> (rx_valid && $stable(rx_data))); // R8
  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we) |=> $stable({len, na, ni, dout, wide})); // R10
endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        quad_lanes = 1'b0;
  logic        addr_we = 1'b0;
  logic [31:0] addr_wdata = '0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_ready;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ack = 1'b0;
  logic        busy, sck, cs_n;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in = '0;

  always #4 clk = ~clk;

  flash_cmd_seq u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .quad_lanes(quad_lanes),
    .addr_we(addr_we), .addr_wdata(addr_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ack(rx_ack),
    .busy(busy), .sck(sck), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  int errors = 0;
  int checks = 0;
  logic [3:0] exp_out [0:511];
  logic [3:0] exp_oe  [0:511];
  logic [3:0] resp    [0:511];
  logic [3:0] cap_out [0:511];
  logic [3:0] cap_oe  [0:511];
  logic [7:0] txb [0:31];
  logic [7:0] rxb [0:31];
  int n_rise = 0;
  int n_exp;
  logic [31:0] cur_addr = '0;

  always @(posedge sck or negedge cs_n) begin
    if (sck) begin
      if (n_rise < 512) begin
        cap_out[n_rise] = io_out;
        cap_oe[n_rise]  = io_oe;
      end
      n_rise = n_rise + 1;
    end else begin
      n_rise = 0;
    end
  end

  always @(negedge sck) io_in = (n_rise < 512) ? resp[n_rise] : 4'h0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint got, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s got %0h expected %0h", tag, what, got, expv);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete got 0 expected 1");
    finish_run();
  end

  function automatic int addr_bytes(input int ff);
    if (ff <= 1) return 0;
    if (ff >= 5) return 4;
    return ff - 1;
  endfunction

  task automatic push(inout int s, input logic [3:0] o, input logic [3:0] e,
                      input logic [3:0] r);
    exp_out[s] = o;
    exp_oe[s]  = e;
    resp[s]    = r;
    s++;
  endtask

  task automatic run_frame(input logic [31:0] a, input logic wr_addr,
                           input logic [31:0] cmd, input logic quad,
                           input int gap, input int hold, input logic poke);
    int ff, na, ni, len, w, spb, hdr, s, msk;
    logic dout, wd;
    bit bad;
    int bad_s;
    ff   = int'(cmd[23:21]);
    na   = addr_bytes(ff);
    ni   = int'(cmd[18:16]);
    len  = int'(cmd[13:0]);
    dout = cmd[15];
    wd   = (cmd[20:19] != 2'b00);
    w    = wd ? (quad ? 4 : 2) : 1;
    spb  = 8 / w;
    msk  = (1 << w) - 1;
    hdr  = 8 + 8 * na + 8 * ni;
    if (wr_addr) cur_addr = a;
    for (int i = 0; i < 32; i++) begin
      txb[i] = 8'($urandom);
      rxb[i] = 8'($urandom);
    end
    s = 0;
    for (int k = 7; k >= 0; k--) push(s, {3'b0, cmd[24 + k]}, 4'b0001, 4'hA);
    for (int b = na - 1; b >= 0; b--)
      for (int k = 7; k >= 0; k--) push(s, {3'b0, cur_addr[8 * b + k]}, 4'b0001, 4'h5);
    for (int k = 0; k < 8 * ni; k++) push(s, 4'b0000, 4'b0001, 4'hF);
    for (int b = 0; b < len; b++)
      for (int k = 0; k < spb; k++) begin
        int sft;
        sft = 8 - w * (k + 1);
        if (dout)
          push(s, 4'((int'(txb[b]) >> sft) & msk), 4'(msk), 4'h0);
        else if (w == 1)
          push(s, 4'b0000, 4'b0001, {2'b00, rxb[b][sft], 1'b0});
        else
          push(s, 4'b0000, 4'b0000, 4'((int'(rxb[b]) >> sft) & msk));
      end
    n_exp = s;

    @(negedge clk);
    quad_lanes = quad;
    if (wr_addr) begin
      addr_we = 1'b1;
      addr_wdata = a;
      @(negedge clk);
      addr_we = 1'b0;
    end
    cmd_we = 1'b1;
    cmd_wdata = cmd;
    @(negedge clk);
    cmd_we = 1'b0;
    check(busy && !cs_n, "R2", "busy/cs_n after command write", {busy, cs_n}, 2'b10);

    fork
      begin
        if (dout)
          for (int i = 0; i < len; i++) begin
            int g;
            g = (i == 0 && hold > 0) ? hold : int'($urandom % (gap + 1));
            repeat (g) @(negedge clk);
            tx_valid = 1'b1;
            tx_data = txb[i];
            while (!tx_ready) @(negedge clk);
            @(negedge clk);
            tx_valid = 1'b0;
          end
      end
      begin
        if (!dout)
          for (int i = 0; i < len; i++) begin
            if (i == 0 && hold > 0) repeat (hold) @(negedge clk);
            while (!rx_valid) @(negedge clk);
            check(rx_data == rxb[i], "R8", "received byte", rx_data, rxb[i]);
            repeat ($urandom % (gap + 1)) @(negedge clk);
            rx_ack = 1'b1;
            @(negedge clk);
            rx_ack = 1'b0;
          end
      end
      begin
        if (hold > 0) begin
          repeat (hold - 5) @(negedge clk);
          if (dout) begin
            check(n_rise == hdr && sck == 1'b0 && busy, "R7",
                  "slots sent while output byte missing", n_rise, hdr);
          end else begin
            check(n_rise == hdr + spb && sck == 1'b0 && rx_valid, "R8",
                  "slots sent while input byte unconsumed", n_rise, hdr + spb);
            check(tx_ready == 1'b0, "R7", "tx_ready during input command", tx_ready, 0);
          end
        end
      end
      begin
        if (poke) begin
          repeat (20) @(negedge clk);
          cmd_we = 1'b1;
          cmd_wdata = 32'h0207_0005;
          addr_we = 1'b1;
          addr_wdata = 32'hDEAD_BEEF;
          @(negedge clk);
          cmd_we = 1'b0;
          addr_we = 1'b0;
        end
      end
    join

    while (busy) @(negedge clk);
    check(n_rise == n_exp, "R9", "slot count when busy falls", n_rise, n_exp);
    check(cs_n && !sck, "R9", "cs_n/sck when idle", {cs_n, sck}, 2'b10);
    check(tx_ready == 1'b0, "R7", "tx_ready after frame", tx_ready, 0);
    for (int region = 0; region < 4; region++) begin
      int lo, hi;
      string tag;
      case (region)
        0: begin lo = 0; hi = 8; tag = "R2"; end
        1: begin lo = 8; hi = 8 + 8 * na; tag = "R3"; end
        2: begin lo = 8 + 8 * na; hi = hdr; tag = "R4"; end
        default: begin lo = hdr; hi = n_exp; tag = wd ? "R6" : "R5"; end
      endcase
      if (hi > lo && n_rise == n_exp) begin
        bad = 1'b0;
        bad_s = lo;
        for (int k = lo; k < hi; k++)
          if (!bad && (cap_out[k] !== exp_out[k] || cap_oe[k] !== exp_oe[k])) begin
            bad = 1'b1;
            bad_s = k;
          end
        check(!bad, tag, $sformatf("lanes/enables at slot %0d", bad_s),
              {cap_oe[bad_s], cap_out[bad_s]}, {exp_oe[bad_s], exp_out[bad_s]});
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(!busy && cs_n && !sck && io_oe == 4'h0 && !rx_valid && !tx_ready, "R1",
          "reset state {busy,cs_n,sck,oe,rx_valid,tx_ready}",
          {busy, cs_n, sck, io_oe, rx_valid, tx_ready}, 9'b0_1_0_0000_0_0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && cs_n && !sck && io_oe == 4'h0, "R1", "idle after reset release",
          {busy, cs_n, sck, io_oe}, 7'b0100000);

    run_frame(32'h0, 1'b0, 32'h9F20_0006, 1'b0, 2, 0, 1'b0);           // R2 R5 R6 serial read
    run_frame(32'h0012_3456, 1'b1, 32'hD880_0000, 1'b0, 0, 0, 1'b0);   // R5 zero length, 3 addr
    run_frame(32'hA1B2_C3D4, 1'b1, 32'h13E0_0002, 1'b0, 1, 0, 1'b0);   // R3 clip 7 -> 4
    run_frame(32'hFFFF_FFFF, 1'b1, 32'h0500_0001, 1'b0, 1, 0, 1'b0);   // R3 form 0 -> none
    run_frame(32'h0000_7A5C, 1'b1, 32'h6B69_0005, 1'b1, 2, 0, 1'b0);   // R4 R6 quad read
    run_frame(32'h0000_0100, 1'b1, 32'h32C8_8004, 1'b0, 2, 0, 1'b0);   // R6 dual write
    run_frame(32'h0000_0200, 1'b1, 32'h0260_8003, 1'b0, 0, 300, 1'b0); // R7 tx stall
    run_frame(32'h0000_0300, 1'b1, 32'h0340_0003, 1'b0, 0, 300, 1'b0); // R8 rx stall
    run_frame(32'h0055_AA11, 1'b1, 32'h0280_8004, 1'b0, 0, 200, 1'b1); // R10 poke mid-frame
    run_frame(32'h0, 1'b0, 32'h0360_0000, 1'b0, 0, 0, 1'b0);           // R10 old address kept

    for (int n = 0; n < 30; n++) begin
      logic [31:0] c;
      c = '0;
      c[31:24] = 8'($urandom);
      c[23:21] = 3'(1 + $urandom % 5);
      c[20:19] = 2'($urandom % 2);
      c[18:16] = 3'($urandom % 4);
      c[15]    = 1'($urandom % 2);
      c[13:0]  = 14'($urandom % 13);
      run_frame($urandom, 1'b1, c, 1'($urandom % 2), 3, 0, 1'b0);
    end
    finish_run();
  end
endmodule